// File: doc/BRIEF.md
# Double-Buffered Sample Streaming DMA

This block feeds a converter from memory one sample word at a time. It holds two buffer descriptors, each an address and a word count. The active descriptor is the one being played out. The standby descriptor is the one queued behind it. Every rising edge on the trigger input, normally driven by a timer output, fetches one word from a synchronous sample memory. That word goes to the sample output with a one-cycle valid strobe.

When the active descriptor runs out and the standby count is nonzero, the standby descriptor takes its place in the same cycle, so playback has no gap. The standby count is then cleared. Software gets a whole buffer's duration to queue the next descriptor. If nothing is queued, playback stops. Two sticky flags report these events: one for the end of a buffer and one for both descriptors being empty. Either flag can drive the interrupt line.

Top module: `dbuf_stream_dma`

## Requirements
- R1: After reset, the channel is disabled and both counts are zero. `flag_end`, `flag_empty`, `irq`, `mem_rd_en` and `smp_valid` are all low.
- R2: Writes use `wr_sel` codes as follows: 0 = active address, 1 = active count, 2 = standby address, 3 = standby count, 4 = control, 5 = interrupt enable. In control, bit 8 is transmit enable. Control bit 0 (receive enable) is accepted but has no effect on streaming. In interrupt enable, bit 0 selects `flag_end` and bit 1 selects `flag_empty`.
- R3: A transfer happens when the trigger rises while transmit is enabled and the active count is nonzero. In that cycle, `mem_rd_en` is high and `mem_addr` equals the active address. One cycle later, `smp_valid` is high for one cycle and `smp_data` is the word the memory returns.
- R4: A transfer that does not end the active buffer adds the sample width to the active address and subtracts one from the active count. The width is 2 in half-word mode (`WORD_MODE`=0) and 4 in word mode.
- R5: The transfer that takes the active count from 1 to 0 is the buffer end. If the standby count is nonzero at that point, the standby address and count become the active ones and the standby count becomes zero.
- R6: At a buffer end with a standby count of zero, the active count becomes zero, `flag_empty` is set, and streaming halts until software writes a count.
- R7: Every buffer end sets `flag_end`. A nonzero write to the standby count clears both flags. A nonzero write to the active count clears only `flag_empty`. Writes of zero clear neither flag.
- R8: `irq` is high exactly when an enabled flag is set.
- R9: A trigger is ignored when transmit is disabled or the active count is zero. Ignored means no strobe, no memory read, and no change to the address or count. The next real transfer shows this, because it resumes at the unchanged address.
- R10: A trigger held high for several cycles moves only one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select code |
| wr_data | input | 32 | Register write data |
| trig_in | input | 1 | Sample trigger from a timer |
| mem_rd_en | output | 1 | Sample memory read request |
| mem_addr | output | ADDR_W | Sample memory byte address |
| mem_rdata | input | DATA_W | Sample memory data, one cycle after the request |
| smp_data | output | DATA_W | Sample word to the converter |
| smp_valid | output | 1 | One-cycle strobe marking `smp_data` valid |
| flag_end | output | 1 | Sticky buffer-end flag |
| flag_empty | output | 1 | Sticky flag: both descriptors exhausted |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that register writes never arrive in the same cycle as a transfer; they check descriptor updates only in cycles without a write. They also assume the memory answers every read in the next cycle. The bench makes both true: it serializes each write and each trigger pulse into separate cycles. Its memory model is a one-cycle registered function of the address. Random runs queue a standby descriptor only while the standby count is zero, which mimics software reacting to the buffer-end flag.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
   typedef enum logic [2:0] {
      SEL_CUR_ADDR = 3'd0,
      SEL_CUR_CNT  = 3'd1,
      SEL_NXT_ADDR = 3'd2,
      SEL_NXT_CNT  = 3'd3,
      SEL_CTRL     = 3'd4,
      SEL_IEN      = 3'd5
   } reg_sel_e;

   localparam int CTRL_TX_BIT = 8;
   localparam int CTRL_RX_BIT = 0;
   localparam int IEN_END_BIT = 0;
   localparam int IEN_EMP_BIT = 1;
endpackage

// File: rtl/dbs_trig.sv
module dbs_trig #(
   parameter bit EDGE_MODE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_in,
   output logic trig_evt
);
   generate
      if (EDGE_MODE) begin : g_edge
         logic trig_q;
         always_ff @(posedge clk) begin
            if (!rst_n) trig_q <= 1'b0;
            else        trig_q <= trig_in;
         end
         assign trig_evt = trig_in & ~trig_q;
      end else begin : g_level
         assign trig_evt = trig_in;
      end
   endgenerate
endmodule

// File: rtl/dbs_slots.sv
module dbs_slots
   import dbs_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int CNT_W     = 8,
   parameter bit WORD_MODE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  reg_sel_e          wr_sel,
   input  logic [31:0]       wr_data,
   input  logic              xfer,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [CNT_W-1:0]  cur_cnt,
   output logic [CNT_W-1:0]  nxt_cnt,
   output logic              ev_end,
   output logic              ev_drain
);
   logic [ADDR_W-1:0] nxt_addr;
   logic [ADDR_W-1:0] step;

   generate
      if (WORD_MODE) begin : g_word
         assign step = ADDR_W'(4);
      end else begin : g_half
         assign step = ADDR_W'(2);
      end
   endgenerate

   assign ev_end   = xfer && (cur_cnt == CNT_W'(1));
   assign ev_drain = ev_end && (nxt_cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_addr <= '0;
         cur_cnt  <= '0;
         nxt_addr <= '0;
         nxt_cnt  <= '0;
      end else begin
         if (xfer) begin
            if (ev_end && (nxt_cnt != '0)) begin
               cur_addr <= nxt_addr;
               cur_cnt  <= nxt_cnt;
               nxt_cnt  <= '0;
            end else begin
               cur_addr <= cur_addr + step;
               cur_cnt  <= cur_cnt - CNT_W'(1);
            end
         end
         if (wr_en) begin
            case (wr_sel)
               SEL_CUR_ADDR: cur_addr <= wr_data[ADDR_W-1:0];
               SEL_CUR_CNT:  cur_cnt  <= wr_data[CNT_W-1:0];
               SEL_NXT_ADDR: nxt_addr <= wr_data[ADDR_W-1:0];
               SEL_NXT_CNT:  nxt_cnt  <= wr_data[CNT_W-1:0];
               default: ;
            endcase
         end
      end
   end

   // R4
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && cur_cnt > CNT_W'(1) && !wr_en) |=>
      (cur_cnt == $past(cur_cnt) - CNT_W'(1)) && (cur_addr == $past(cur_addr) + step));

   // R5
   promote_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && cur_cnt == CNT_W'(1) && nxt_cnt != '0 && !wr_en) |=>
      (cur_cnt == $past(nxt_cnt)) && (nxt_cnt == '0));

   // R6
   drain_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && cur_cnt == CNT_W'(1) && nxt_cnt == '0 && !wr_en) |=> (cur_cnt == '0));
endmodule

// File: rtl/dbs_ctl.sv
module dbs_ctl
   import dbs_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  reg_sel_e    wr_sel,
   input  logic [31:0] wr_data,
   input  logic        ev_end,
   input  logic        ev_drain,
   output logic        tx_en,
   output logic        flag_end,
   output logic        flag_empty,
   output logic        irq
);
   logic [1:0] ien;
   logic       rx_en;
   logic       nz_data;
   logic       clr_end;
   logic       clr_emp;

   assign nz_data = (wr_data[CNT_W-1:0] != '0);
   assign clr_end = wr_en && (wr_sel == SEL_NXT_CNT) && nz_data;
   assign clr_emp = clr_end || (wr_en && (wr_sel == SEL_CUR_CNT) && nz_data);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_en      <= 1'b0;
         rx_en      <= 1'b0;
         ien        <= '0;
         flag_end   <= 1'b0;
         flag_empty <= 1'b0;
      end else begin
         if (wr_en && wr_sel == SEL_CTRL) begin
            tx_en <= wr_data[CTRL_TX_BIT];
            rx_en <= wr_data[CTRL_RX_BIT];
         end
         if (wr_en && wr_sel == SEL_IEN) begin
            ien <= {wr_data[IEN_EMP_BIT], wr_data[IEN_END_BIT]};
         end
         if (ev_end)       flag_end <= 1'b1;
         else if (clr_end) flag_end <= 1'b0;
         if (ev_drain)     flag_empty <= 1'b1;
         else if (clr_emp) flag_empty <= 1'b0;
      end
   end

   assign irq = (flag_end & ien[IEN_END_BIT]) | (flag_empty & ien[IEN_EMP_BIT]);

   // R7
   end_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_end |=> flag_end);

   // R7
   empty_implies_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_empty) |-> flag_end);
endmodule

// File: rtl/dbuf_stream_dma.sv
module dbuf_stream_dma
   import dbs_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int CNT_W     = 8,
   parameter int DATA_W    = 16,
   parameter bit WORD_MODE = 1'b0,
   parameter bit EDGE_MODE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [31:0]       wr_data,
   input  logic              trig_in,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] smp_data,
   output logic              smp_valid,
   output logic              flag_end,
   output logic              flag_empty,
   output logic              irq
);
   generate
      if (ADDR_W < 3 || ADDR_W > 32) begin : g_bad_addr
         $error("ADDR_W must lie in 3..32");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
         $error("CNT_W must lie in 1..32");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be positive");
      end
   endgenerate

   reg_sel_e          sel;
   logic              trig_evt;
   logic              tx_en;
   logic              xfer;
   logic              ev_end;
   logic              ev_drain;
   logic [ADDR_W-1:0] cur_addr;
   logic [CNT_W-1:0]  cur_cnt;
   logic [CNT_W-1:0]  nxt_cnt;
   logic              valid_q;

   assign sel = reg_sel_e'(wr_sel);

   dbs_trig #(.EDGE_MODE(EDGE_MODE)) trig_i (
      .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_evt(trig_evt)
   );

   assign xfer = trig_evt && tx_en && (cur_cnt != '0);

   dbs_slots #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORD_MODE(WORD_MODE)) slots_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(sel), .wr_data(wr_data),
      .xfer(xfer), .cur_addr(cur_addr), .cur_cnt(cur_cnt), .nxt_cnt(nxt_cnt),
      .ev_end(ev_end), .ev_drain(ev_drain)
   );

   dbs_ctl #(.CNT_W(CNT_W)) ctl_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(sel), .wr_data(wr_data),
      .ev_end(ev_end), .ev_drain(ev_drain), .tx_en(tx_en),
      .flag_end(flag_end), .flag_empty(flag_empty), .irq(irq)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) valid_q <= 1'b0;
      else        valid_q <= xfer;
   end

   assign mem_rd_en = xfer;
   assign mem_addr  = cur_addr;
   assign smp_valid = valid_q;
   assign smp_data  = mem_rdata;

   // R6
   empty_no_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_empty |-> !mem_rd_en);

   // R3
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |-> !$past(smp_valid) || $past(mem_rd_en));

   // R10
   held_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (EDGE_MODE && trig_in && $past(trig_in)) |-> !mem_rd_en);
endmodule

// File: tb/dbuf_stream_dma_tb_top.sv
module dbuf_stream_dma_tb_top;
   localparam int ADDR_W = 16;
   localparam int CNT_W  = 8;
   localparam int DATA_W = 16;
   localparam int STEP   = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [2:0]        wr_sel = '0;
   logic [31:0]       wr_data = '0;
   logic              trig_in = 1'b0;
   logic              mem_rd_en;
   logic [ADDR_W-1:0] mem_addr;
   logic [DATA_W-1:0] mem_rdata;
   logic [DATA_W-1:0] smp_data;
   logic              smp_valid;
   logic              flag_end;
   logic              flag_empty;
   logic              irq;

   int total = 0;
   int fails = 0;
   bit done = 1'b0;

   // bench model
   logic [ADDR_W-1:0] m_ca, m_na;
   logic [CNT_W-1:0]  m_cc, m_nc;
   logic              m_tx, m_fe, m_fm;
   logic [1:0]        m_ien;

   always #5 clk = ~clk;

   dbuf_stream_dma #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W),
                     .WORD_MODE(1'b0), .EDGE_MODE(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .trig_in(trig_in), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .smp_data(smp_data), .smp_valid(smp_valid),
      .flag_end(flag_end), .flag_empty(flag_empty), .irq(irq)
   );

   function automatic logic [DATA_W-1:0] mem_fn(input logic [ADDR_W-1:0] a);
      return DATA_W'(a * 16'd3 + 16'd17);
   endfunction

   always_ff @(posedge clk) begin
      if (mem_rd_en) mem_rdata <= mem_fn(mem_addr);
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_flags(input string req);
      check({req, " flag_end"}, 32'(flag_end), 32'(m_fe));
      check({req, " flag_empty"}, 32'(flag_empty), 32'(m_fm));
      check({req, " irq"}, 32'(irq), 32'((m_fe & m_ien[0]) | (m_fm & m_ien[1])));
   endtask

   task automatic wr(input logic [2:0] sel, input logic [31:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
      case (sel)
         3'd0: m_ca = data[ADDR_W-1:0];
         3'd1: begin m_cc = data[CNT_W-1:0]; if (m_cc != 0) m_fm = 1'b0; end
         3'd2: m_na = data[ADDR_W-1:0];
         3'd3: begin m_nc = data[CNT_W-1:0]; if (m_nc != 0) begin m_fe = 1'b0; m_fm = 1'b0; end end
         3'd4: m_tx = data[8];
         3'd5: m_ien = data[1:0];
         default: ;
      endcase
      check_flags("R7/R8 after write");
   endtask

   // one trigger pulse of hold cycles, checked against the model
   task automatic trig(input string req, input int hold);
      logic go;
      logic [ADDR_W-1:0] ea;
      @(negedge clk);
      trig_in = 1'b1;
      go = m_tx && (m_cc != 0);
      ea = m_ca;
      #1;
      check({req, " R3 rd_en"}, 32'(mem_rd_en), 32'(go));
      if (go) check({req, " R3/R4 addr"}, 32'(mem_addr), 32'(ea));
      @(posedge clk); #1;
      check({req, " R3 valid"}, 32'(smp_valid), 32'(go));
      if (go) check({req, " R3 data"}, 32'(smp_data), 32'(mem_fn(ea)));
      if (go) begin
         if (m_cc == 1) begin
            m_fe = 1'b1;
            if (m_nc != 0) begin m_ca = m_na; m_cc = m_nc; m_nc = '0; end
            else begin m_cc = '0; m_ca = m_ca + ADDR_W'(STEP); m_fm = 1'b1; end
         end else begin
            m_cc = m_cc - 1'b1; m_ca = m_ca + ADDR_W'(STEP);
         end
      end
      for (int i = 1; i < hold; i++) begin
         @(posedge clk); #1;
         check({req, " R10 held trigger no strobe"}, 32'(smp_valid), 32'(0));
      end
      @(negedge clk);
      trig_in = 1'b0;
      check_flags(req);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         fails++; total++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      m_ca = '0; m_na = '0; m_cc = '0; m_nc = '0;
      m_tx = 1'b0; m_fe = 1'b0; m_fm = 1'b0; m_ien = '0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      // R1 reset state
      check("R1 valid", 32'(smp_valid), 0);
      check("R1 rd_en", 32'(mem_rd_en), 0);
      check_flags("R1");

      // R9 disabled channel, counts zero
      trig("R9 disabled empty", 1);
      wr(3'd0, 32'h0100);
      wr(3'd1, 32'd3);
      trig("R9 disabled loaded", 1);
      // R2 receive enable only: no effect
      wr(3'd4, 32'h0001);
      trig("R2 rx-only ignored", 1);
      wr(3'd4, 32'h0100);
      wr(3'd2, 32'h0200);
      wr(3'd3, 32'd2);
      trig("R9 resume at unchanged addr", 1);
      trig("R4 step", 1);
      trig("R5 promote", 1);
      wr(3'd5, 32'h1);
      wr(3'd3, 32'd0);            // R7 zero write keeps flag
      wr(3'd2, 32'h0300);
      wr(3'd3, 32'd1);            // R7 nonzero clears
      trig("R5 second buffer", 1);
      trig("R5 promote single", 1);
      trig("R6 drain", 1);
      trig("R9 after drain", 1);
      wr(3'd5, 32'h2);            // R8 empty interrupt
      wr(3'd1, 32'd0);            // R7 zero active count keeps empty flag
      wr(3'd0, 32'h0400);
      wr(3'd1, 32'd4);            // R7 active count clears only empty
      trig("R10 held trigger", 4);
      trig("R4 after hold", 1);

      // random streaming with software refill
      for (int it = 0; it < 300; it++) begin
         int r;
         r = int'($urandom(32'd1234 + 32'(it)) % 10);
         if (m_nc == 0 && r < 3) begin
            wr(3'd2, 32'($urandom & 32'hFFFE));
            wr(3'd3, 32'(1 + $urandom % 4));
         end else if (r == 3) begin
            wr(3'd5, 32'($urandom % 4));
         end else if (m_cc == 0 && r == 4) begin
            wr(3'd1, 32'(1 + $urandom % 3));
         end else begin
            repeat ($urandom % 3) @(negedge clk);
            trig("R3/R5 random", 1 + int'($urandom % 2));
         end
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule